// File: doc/BRIEF.md
# Selectable Clock Divider with Gated Fanout

The block receives one reference clock and derives from it a single clock at the reference rate or at one half, one quarter or one eighth of that rate. A two-bit select input picks the ratio. The chosen clock goes to eight output lines, and each line has its own active-low disable bit. In pass-through mode the reference is gated straight to the lines, so their duty cycle follows the reference. In the divided modes the lines come from a free-running counter and have an even 50% duty cycle.

The select and disable inputs may change at any time relative to the reference. Both are brought into the reference domain through synchronizer flops. A new ratio takes effect only at a falling reference edge where the counter has just wrapped to zero. At that point the old clock and the new clock are both low, so a ratio change never produces a runt pulse. Each line's enable flop is also updated on a falling edge, and only while the divided level is low. An output is therefore never switched on or off partway through a high pulse.

A disabled line stands for a high-impedance driver. Its drive-enable flag is low and its data line is parked at 0, which keeps the model two-state.

Top module: `clk_div_fanout`

## Requirements
- R1: Select value 00 is pass-through. An enabled output is high while the reference is high and low while it is low. This is also the state after reset.
- R2: Select values 01, 10 and 11 divide the reference by 2, 4 and 8. An enabled output is high for exactly N/2 reference cycles and then low for N/2 cycles, where N is the divide ratio.
- R3: While reset is asserted, every drive-enable flag is 0, every output line is 0 and the divider returns to pass-through.
- R4: Disable bit i (bit 0 maps to output 0) equal to 1 sets drive-enable flag i to 0 and holds output line i at 0. A bit equal to 0 sets the flag to 1 and the line toggles. Each bit affects only its own output.
- R5: All enabled outputs carry the identical waveform at all times.
- R6: A select change passes through a two-flop synchronizer and takes effect only on a falling reference edge where the divide counter is zero. No output pulse, high or low, is shorter than half a reference period across any ratio change.
- R7: A drive-enable flag changes only on a falling reference edge while the selected clock is low. A newly enabled output never starts with a partial high pulse, and a disabled output never truncates one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Divide select (00 /1, 01 /2, 10 /4, 11 /8), asynchronous |
| out_dis_i | input | 8 | Per-output disable, 1 disables, asynchronous |
| clk_o | output | 8 | Gated output clocks, parked at 0 when disabled |
| clk_oe_o | output | 8 | Drive-enable per output, 0 represents high impedance |

## Verification
The bench checks each select code by its run length. If a decoder maps a code to the wrong ratio, or puts the duty on the wrong counter bit, the high and low runs come out at the wrong length. A monitor times every edge on every output across the whole run. A design that switches ratio on a rising edge, or while the old clock is high, leaves a runt or zero-width pulse that the monitor records. The bench also applies disable patterns with outputs in both states. A swapped or inverted bit, an output left toggling while disabled, or an enable gated while the clock is high shows up as a flag mismatch, a stray toggle or a short pulse.

// File: rtl/clk_div_pkg.sv
`timescale 1ns/1ps
package clk_div_pkg;
  // counter width needed for the largest ratio a select width can encode
  function automatic int cnt_width(input int sel_w);
    return (1 << sel_w) - 1;
  endfunction
endpackage

// File: rtl/cdc_sync.sv
`timescale 1ns/1ps
module cdc_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/div_core.sv
`timescale 1ns/1ps
module div_core #(
  parameter int SEL_W = 2,
  parameter int CNT_W = clk_div_pkg::cnt_width(SEL_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] mode_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             src_clk_o,
  output logic             gate_ok_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] mode_q;
  logic             lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // ratio switch at the falling edge after a wrap: old and new clocks both low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mode_q <= '0;
    else if (cnt_q == '0)  mode_q <= sel_i;
  end

  always_comb begin
    lvl = 1'b0;
    for (int b = 0; b < CNT_W; b++) begin
      if (int'(mode_q) == b + 1) lvl = cnt_q[b];
    end
  end

  assign src_clk_o = (mode_q == '0) ? clk_i : lvl;
  // registered-only term: safe to sample on the falling edge
  assign gate_ok_o = (mode_q == '0) | ~lvl;
  assign mode_o    = mode_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/out_gate.sv
`timescale 1ns/1ps
module out_gate #(
  parameter int NUM_OUT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gate_ok_i,
  input  logic               src_clk_i,
  input  logic [NUM_OUT-1:0] en_req_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] oe_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    logic en_q;

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        en_q <= 1'b0;
      else if (gate_ok_i) en_q <= en_req_i[g];
    end

    assign clk_o[g] = src_clk_i & en_q;
    assign oe_o[g]  = en_q;
  end
endmodule

// File: rtl/clk_div_fanout.sv
`timescale 1ns/1ps
module clk_div_fanout #(
  parameter int NUM_OUT     = 8,
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = clk_div_pkg::cnt_width(SEL_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   div_sel_i,
  input  logic [NUM_OUT-1:0] out_dis_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic [NUM_OUT-1:0] clk_oe_o
);
  logic [SEL_W-1:0]   sel_sync;
  logic [NUM_OUT-1:0] dis_sync;
  logic [SEL_W-1:0]   mode_w;
  logic [CNT_W-1:0]   cnt_w;
  logic               src_clk;
  logic               gate_ok;

  cdc_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sel_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (div_sel_i),
    .q_o   (sel_sync)
  );

  cdc_sync #(.WIDTH(NUM_OUT), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_dis_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (out_dis_i),
    .q_o   (dis_sync)
  );

  div_core #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_sync),
    .mode_o   (mode_w),
    .cnt_o    (cnt_w),
    .src_clk_o(src_clk),
    .gate_ok_o(gate_ok)
  );

  out_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gate_ok_i(gate_ok),
    .src_clk_i(src_clk),
    .en_req_i (~dis_sync),
    .clk_o    (clk_o),
    .oe_o     (clk_oe_o)
  );
endmodule

// File: rtl/clk_div_fanout_chk.sv
`timescale 1ns/1ps
module clk_div_fanout_chk #(
  parameter int NUM_OUT = 8,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = clk_div_pkg::cnt_width(SEL_W)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [NUM_OUT-1:0] clk_oe_o,
  input logic [SEL_W-1:0]   mode_w,
  input logic [CNT_W-1:0]   cnt_w
);
  // R3: reset leaves every output undriven and low
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r3: assert (clk_oe_o == '0 && clk_o == '0 && mode_w == '0)
        else $error("p_reset_quiet_r3");
    end
  end

  // R4, R5: enabled lanes agree, disabled lanes parked low
  p_same_wave_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_o == (clk_oe_o & {NUM_OUT{|clk_o}}));

  // R6: ratio changes only after a falling edge seen with the counter at zero
  p_switch_at_wrap_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !$stable(mode_w) |-> $past(cnt_w) == '0);

  // R7: a lane switched on was low through the rest of that low phase
  p_enable_in_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clk_oe_o & ~$past(clk_oe_o)) & clk_o) == '0);

  // R2: counter advances by one each reference cycle
  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w == CNT_W'($past(cnt_w) + 1'b1) || $past(!rst_ni));
endmodule

bind clk_div_fanout clk_div_fanout_chk #(
  .NUM_OUT(NUM_OUT),
  .SEL_W  (SEL_W),
  .CNT_W  (CNT_W)
) u_chk (.*);

// File: tb/clk_div_fanout_tb_top.sv
`timescale 1ns/1ps
module clk_div_fanout_tb_top;
  localparam int NO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sel = 2'b00;
  logic [NO-1:0] dis = '1;
  logic [NO-1:0] clk_o;
  logic [NO-1:0] oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  clk_div_fanout dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .div_sel_i(sel),
    .out_dis_i(dis),
    .clk_o    (clk_o),
    .clk_oe_o (oe_o)
  );

  // edge-interval monitor for runts on every lane
  realtime last_t [NO];
  logic [NO-1:0] prev_o = '0;
  int runts [NO];
  initial for (int k = 0; k < NO; k++) begin last_t[k] = 0; runts[k] = 0; end

  always @(clk_o) begin
    for (int k = 0; k < NO; k++) begin
      if (clk_o[k] !== prev_o[k]) begin
        if (rst_n && ($realtime - last_t[k]) < 10.0) runts[k]++;
        last_t[k] = $realtime;
        prev_o[k] = clk_o[k];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // align to rising edge + 5 ns (clock high phase)
  task automatic to_high();
    @(posedge clk);
    #5;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  // sample lane 0 twice per cycle, check all interior runs equal exp_run
  task automatic run_len(input int exp_run, input int nsamp, input string req);
    logic prev;
    int cur, nruns, bad_len;
    bit first;
    to_high();
    prev = clk_o[0];
    cur = 1; nruns = 0; first = 1'b1; bad_len = 0;
    for (int k = 1; k < nsamp; k++) begin
      #10;
      if (clk_o[0] === prev) cur++;
      else begin
        if (!first) begin
          nruns++;
          if (cur != exp_run) bad_len = cur;
        end
        first = 1'b0;
        cur = 1;
        prev = clk_o[0];
      end
    end
    check(bad_len == 0 && nruns >= 2, req, "run length", bad_len, exp_run);
  endtask

  task automatic t_reset();
    #3;
    check(oe_o == '0, "R3", "oe during reset", oe_o, 0);
    check(clk_o == '0, "R3", "clk during reset", clk_o, 0);
    #40;
    rst_n = 1'b1;
    wait_cycles(4);
    check(oe_o == '0, "R3", "oe after reset with all disabled", oe_o, 0);
  endtask

  task automatic t_passthrough();
    dis = 8'h00;
    wait_cycles(12);
    check(oe_o == 8'hff, "R4", "all enabled", oe_o, 8'hff);
    check(clk_o == 8'hff, "R1", "high phase follows reference", clk_o, 8'hff);
    #10;
    check(clk_o == 8'h00, "R1", "low phase follows reference", clk_o, 8'h00);
    run_len(1, 32, "R1");
  endtask

  task automatic t_mode(input logic [1:0] s, input int ratio, input string req);
    sel = s;
    wait_cycles(24);
    run_len(ratio, 8 * ratio, req);
  endtask

  task automatic t_mask(input logic [NO-1:0] m);
    logic [NO-1:0] seen_hi, seen_lo;
    bit agree;
    dis = m;
    wait_cycles(16);
    check(oe_o == ~m, "R4", "drive-enable vs disable", oe_o, ~m);
    seen_hi = '0; seen_lo = '0; agree = 1'b1;
    for (int k = 0; k < 16; k++) begin
      #10;
      seen_hi |= clk_o;
      seen_lo |= ~clk_o;
      if ((clk_o & ~m) != ({NO{|(clk_o & ~m)}} & ~m)) agree = 1'b0;
    end
    check((seen_hi & m) == '0, "R4", "disabled lanes parked low", seen_hi & m, 0);
    check((seen_hi & seen_lo & ~m) == ~m, "R4", "enabled lanes toggle",
          seen_hi & seen_lo, ~m);
    check(agree, "R5", "enabled lanes identical", clk_o, 0);
  endtask

  task automatic t_switch(input logic [1:0] s_from, input logic [1:0] s_to,
                          input int r_to, input string req);
    sel = s_from;
    wait_cycles(24);
    sel = s_to;
    wait_cycles(24);
    run_len(r_to, 8 * (r_to < 2 ? 2 : r_to), req);
  endtask

  task automatic t_toggle_enables();
    for (int k = 0; k < 6; k++) begin
      dis = (k % 2 == 0) ? 8'h3c : 8'hc3;
      #(7 + 3 * k);
    end
    dis = 8'h00;
    wait_cycles(16);
    check(oe_o == 8'hff, "R7", "settled after enable churn", oe_o, 8'hff);
  endtask

  initial begin
    t_reset();
    t_passthrough();
    t_mode(2'b01, 2, "R2");
    t_mode(2'b10, 4, "R2");
    t_mode(2'b11, 8, "R2");
    t_mask(8'b1010_0101);
    t_mask(8'b0000_0001);
    t_mask(8'b1000_0000);
    sel = 2'b00;
    t_mask(8'b0110_1001);
    dis = 8'h00;
    t_switch(2'b11, 2'b01, 2, "R6");
    t_switch(2'b01, 2'b11, 8, "R6");
    t_switch(2'b10, 2'b00, 1, "R6");
    t_switch(2'b00, 2'b10, 4, "R6");
    sel = 2'b01;
    t_toggle_enables();
    sel = 2'b00;
    t_toggle_enables();
    sel = 2'b11;
    t_toggle_enables();
    for (int k = 0; k < NO; k++)
      check(runts[k] == 0, "R7", $sformatf("no short pulse lane %0d (R6)", k), runts[k], 0);
    done = 1'b1;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule